// File: doc/BRIEF.md
# Watchdog Interval Timer Controller

This block is a supervisory timer that counts ticks from an external prescaler and acts when its 8-bit counter rolls over from 0xFF to 0x00. A single 8-bit control register on a simple register bus picks what the rollover does. It can set a maskable interval interrupt flag, pulse a non-maskable interrupt request, or pulse a system reset request. The register holds three live bits: a run bit, a watchdog-enable bit and a watchdog-action bit. Each of them can only be set by software. Only the reset input returns them to zero.

Software starts the counter, and also restarts it as a "kick", by writing the run bit as 1. That write zeroes the main counter but not the prescaler, so the first rollover after a kick may come a fraction of a tick period early. In interval use, the counter keeps running after each rollover. The interrupt flag then stays set until the external clear input drops it. Turning on watchdog operation while that flag is still set produces an immediate non-maskable request.

Top module: `wdog_interval_ctrl`

## Requirements
- R1: After reset, the register reads 0x00, and intFlag, nmiReq and rstReq are all 0.
- R2: The register lives at address 0xFFF9. A read there returns {run, 0, 0, wdEn, wdAct, 0, 0, 0}, with run at bit 7, wdEn at bit 4 and wdAct at bit 3. Bits 6, 5, 2, 1 and 0 always read 0. Reads at any other address return 0x00, and writes to any other address change nothing.
- R3: Writing 1 to bit 7 sets run. Once run is set, a write with bit 7 at 0 does not clear it, and counting continues.
- R4: Writing 1 to bit 4 sets wdEn, and writing 1 to bit 3 sets wdAct. Neither bit returns to 0 on a later write of 0.
- R5: Every write with bit 7 at 1 zeroes the counter, including when run is already set. The next rollover then needs 256 further ticks.
- R6: The counter advances by one only in a cycle where run is 1 and tickEn is 1. The rollover from 0xFF to 0x00 happens on the 256th tick after a clear.
- R7: When wdEn is 0 (interval mode, wdAct ignored), a rollover sets intFlag one cycle later. intFlag stays at 1 until flagClr is asserted. The counter keeps running, so the next rollover follows 256 ticks later.
- R8: When wdEn is 1 and wdAct is 0, a rollover produces a one-cycle nmiReq pulse. intFlag is not set.
- R9: When wdEn is 1 and wdAct is 1, a rollover produces a one-cycle rstReq pulse. nmiReq does not pulse.
- R10: A write that takes wdEn from 0 to 1 while intFlag is 1 produces a one-cycle nmiReq pulse in the next cycle, whatever bit 3 holds. The same write with intFlag at 0 produces no pulse.
- R11: A counter-clearing write in the same cycle as the tick that would roll the counter over wins: there is no rollover, and counting restarts from 0. A rollover in the same cycle as flagClr leaves intFlag at 1.
- R12: While run is 0, ticks are ignored and no rollover occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Register bus address |
| busWe | input | 1 | Register bus write strobe |
| busWdata | input | 8 | Register bus write data |
| busRdata | output | 8 | Register bus read data (combinational) |
| tickEn | input | 1 | Counting tick from the external prescaler |
| flagClr | input | 1 | Clears the interval interrupt flag |
| intFlag | output | 1 | Maskable interval interrupt request flag |
| nmiReq | output | 1 | Non-maskable interrupt request pulse |
| rstReq | output | 1 | System reset request pulse |

## Verification
Two pairs of events can fall in the same cycle here. The first is a kick write landing on the very tick that would roll the counter over. The bench parks the counter at 0xFF and issues the write with tickEn high. It then judges the result by the flag staying low for 255 further ticks and rising on the 256th. The second is a rollover meeting flagClr. The bench raises both in one cycle while the flag is already set and expects the flag to remain at 1.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int RUN_BIT  = 7;
  localparam int WDEN_BIT = 4;
  localparam int ACT_BIT  = 3;

  typedef struct packed {
    logic clrCnt;
    logic cntEn;
  } wdStrobe_t;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'd0,
    MODE_NMI      = 2'd1,
    MODE_RESET    = 2'd2
  } wdMode_e;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  // a clearing write outranks the tick that would roll over
  assign ovf = strobe.cntEn && !strobe.clrCnt && (cntVal == CNT_TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntVal <= '0;
    else if (strobe.clrCnt) cntVal <= '0;
    else if (strobe.cntEn)  cntVal <= cntVal + 1'b1;
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFF9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickEn,
  input  logic              flagClr,
  input  logic              ovf,
  output wdStrobe_t         strobe,
  output logic              modeRun,
  output logic              modeWd,
  output logic              modeAct,
  output logic              intFlag,
  output logic              nmiReq,
  output logic              rstReq
);
  logic    regHit;
  logic    runSet, wdSet, actSet;
  logic    pendNmi;
  wdMode_e curMode;

  assign regHit  = busWe && (busAddr == REG_ADDR);
  assign runSet  = regHit && busWdata[RUN_BIT];
  assign wdSet   = regHit && busWdata[WDEN_BIT];
  assign actSet  = regHit && busWdata[ACT_BIT];
  assign pendNmi = wdSet && !modeWd && intFlag;

  assign strobe.clrCnt = runSet;
  assign strobe.cntEn  = modeRun && tickEn;

  always_comb begin
    if (!modeWd)      curMode = MODE_INTERVAL;
    else if (!modeAct) curMode = MODE_NMI;
    else              curMode = MODE_RESET;
  end

  // set-only mode bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeRun <= 1'b0;
      modeWd  <= 1'b0;
      modeAct <= 1'b0;
    end else begin
      modeRun <= modeRun | runSet;
      modeWd  <= modeWd  | wdSet;
      modeAct <= modeAct | actSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intFlag <= 1'b0;
      nmiReq  <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      nmiReq <= (ovf && curMode == MODE_NMI) || pendNmi;
      rstReq <= ovf && curMode == MODE_RESET;
      if (ovf && curMode == MODE_INTERVAL) intFlag <= 1'b1;
      else if (flagClr)                    intFlag <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == REG_ADDR) begin
      busRdata[RUN_BIT]  = modeRun;
      busRdata[WDEN_BIT] = modeWd;
      busRdata[ACT_BIT]  = modeAct;
    end
  end
endmodule

// File: rtl/wdog_interval_ctrl.sv
module wdog_interval_ctrl
  import wdog_pkg::*;
#(
  parameter int                CNT_W    = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFF9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickEn,
  input  logic              flagClr,
  output logic              intFlag,
  output logic              nmiReq,
  output logic              rstReq
);
  wdStrobe_t        strobe;
  logic             ovf;
  logic [CNT_W-1:0] cntVal;
  logic             modeRun, modeWd, modeAct;

  wdog_ctrl #(.REG_ADDR(REG_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .tickEn(tickEn),
    .flagClr(flagClr), .ovf(ovf), .strobe(strobe), .modeRun(modeRun),
    .modeWd(modeWd), .modeAct(modeAct), .intFlag(intFlag),
    .nmiReq(nmiReq), .rstReq(rstReq)
  );

  wdog_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntVal(cntVal), .ovf(ovf)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [7:0]       busRdata,
  input logic             flagClr,
  input logic             intFlag,
  input logic             nmiReq,
  input logic             rstReq,
  input logic             modeRun,
  input logic             modeWd,
  input logic             modeAct,
  input logic [CNT_W-1:0] cntVal
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata & 8'h67) == 8'h00);                                   // R2
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    modeRun |=> modeRun);                                           // R3
  AST_WDEN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    modeWd |=> modeWd);                                             // R4
  AST_ACT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    modeAct |=> modeAct);                                           // R4
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !flagClr) |=> intFlag);                             // R7
  AST_NMI_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> !nmiReq);                                            // R8
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);                                            // R9
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({nmiReq, rstReq}));                                    // R9
  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !modeRun |-> (cntVal == '0));                                   // R12
endmodule

bind wdog_interval_ctrl wdog_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .busRdata(busRdata), .flagClr(flagClr),
  .intFlag(intFlag), .nmiReq(nmiReq), .rstReq(rstReq),
  .modeRun(modeRun), .modeWd(modeWd), .modeAct(modeAct), .cntVal(cntVal)
);

// File: tb/test_wdog_interval_ctrl.sv
`timescale 1ns/1ps
module test_wdog_interval_ctrl;
  localparam int CLK_NS = 20;
  localparam logic [15:0] REG = 16'hFFF9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = REG;
  logic busWe = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic tickEn = 1'b0;
  logic flagClr = 1'b0;
  logic intFlag, nmiReq, rstReq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  wdog_interval_ctrl i_wdog_interval_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .tickEn(tickEn),
    .flagClr(flagClr), .intFlag(intFlag), .nmiReq(nmiReq), .rstReq(rstReq)
  );

  // {write data, expected readback}, applied in sequence without reset
  localparam logic [15:0] VEC [8] = '{
    {8'h00, 8'h00}, {8'h67, 8'h00}, {8'h08, 8'h08}, {8'h00, 8'h08},
    {8'h80, 8'h88}, {8'h00, 8'h88}, {8'h10, 8'h98}, {8'hFF, 8'h98}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; busWe = 1'b0; tickEn = 1'b0; flagClr = 1'b0; busAddr = REG;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic tk);
    busAddr = a; busWdata = d; busWe = 1'b1; tickEn = tk;
    @(negedge clk);
    busWe = 1'b0; tickEn = 1'b0; busAddr = REG;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
    end
    tickEn = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    chk("R1 rdata", busRdata, 8'h00);
    chk("R1 flags", {5'd0, intFlag, nmiReq, rstReq}, 8'h00);

    // R2 R3 R4 readback table
    for (int v = 0; v < 8; v++) begin
      wr(REG, VEC[v][15:8], 1'b0);
      chk("R2 R3 R4 table readback", busRdata, VEC[v][7:0]);
    end

    // R2 other address
    doReset();
    wr(16'h1234, 8'hFF, 1'b0);
    chk("R2 foreign write ignored", busRdata, 8'h00);
    busAddr = 16'hFFF8; #1;
    chk("R2 foreign read zero", busRdata, 8'h00);
    busAddr = REG;

    // R12 stopped counter
    tick(300);
    chk("R12 no flag while stopped", {7'd0, intFlag}, 8'h00);

    // R6 R7 interval mode
    wr(REG, 8'h80, 1'b0);
    tick(100);
    repeat (50) @(negedge clk);
    tick(155);
    chk("R6 no flag at 255 ticks", {7'd0, intFlag}, 8'h00);
    tick(1);
    chk("R7 flag at 256th tick", {5'd0, intFlag, nmiReq, rstReq}, 8'h04);
    tick(10);
    chk("R7 flag held", {7'd0, intFlag}, 8'h01);
    flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;
    chk("R7 flag cleared", {7'd0, intFlag}, 8'h00);
    tick(245);
    chk("R7 free-run no early flag", {7'd0, intFlag}, 8'h00);
    tick(1);
    chk("R7 second rollover", {7'd0, intFlag}, 8'h01);
    // R11 rollover with flagClr in same cycle
    tick(255);
    flagClr = 1'b1; tickEn = 1'b1; @(negedge clk); flagClr = 1'b0; tickEn = 1'b0;
    chk("R11 rollover beats clear", {7'd0, intFlag}, 8'h01);
    // R3 zero write keeps counting
    flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;
    wr(REG, 8'h00, 1'b0);
    tick(255);
    chk("R3 still counting, no early flag", {7'd0, intFlag}, 8'h00);
    tick(1);
    chk("R3 run kept after zero write", {7'd0, intFlag}, 8'h01);

    // R5 kick restarts count
    doReset();
    wr(REG, 8'h80, 1'b0);
    tick(200);
    wr(REG, 8'h80, 1'b0);
    tick(255);
    chk("R5 no flag after kick", {7'd0, intFlag}, 8'h00);
    tick(1);
    chk("R5 flag 256 ticks after kick", {7'd0, intFlag}, 8'h01);

    // R11 kick on the rollover tick
    doReset();
    wr(REG, 8'h80, 1'b0);
    tick(255);
    wr(REG, 8'h80, 1'b1);
    chk("R11 kick suppresses rollover", {7'd0, intFlag}, 8'h00);
    tick(255);
    chk("R11 restarted from zero", {7'd0, intFlag}, 8'h00);
    tick(1);
    chk("R11 rollover after restart", {7'd0, intFlag}, 8'h01);

    // R8 watchdog NMI
    doReset();
    wr(REG, 8'h90, 1'b0);
    tick(256);
    chk("R8 nmi pulse", {5'd0, intFlag, nmiReq, rstReq}, 8'h02);
    @(negedge clk);
    chk("R8 nmi one cycle", {7'd0, nmiReq}, 8'h00);

    // R9 watchdog reset
    doReset();
    wr(REG, 8'h98, 1'b0);
    tick(256);
    chk("R9 reset pulse", {5'd0, intFlag, nmiReq, rstReq}, 8'h01);
    @(negedge clk);
    chk("R9 reset one cycle", {7'd0, rstReq}, 8'h00);

    // R10 enabling watchdog with pending flag
    doReset();
    wr(REG, 8'h80, 1'b0);
    tick(256);
    wr(REG, 8'h18, 1'b0);
    chk("R10 pending nmi", {5'd0, intFlag, nmiReq, rstReq}, 8'h06);
    @(negedge clk);
    chk("R10 pending nmi one cycle", {7'd0, nmiReq}, 8'h00);
    doReset();
    wr(REG, 8'h10, 1'b0);
    chk("R10 no nmi without flag", {7'd0, nmiReq}, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule